// File: doc/BRIEF.md
# Subvector Source/Destination Index Sequencer

This block generates the address offsets for a vectorised element move in which each of VL elements is a small subvector. After a start pulse it streams (source offset, destination offset) pairs over a valid/ready handshake. Downstream logic adds these offsets to base register numbers. The source and destination subvector lengths are configured independently. Each side is walked as a two-level loop: the subvector position j is the outer loop and the element number i is the inner loop, and the offset produced is i + VL*j.

When the two subvector lengths match, a single walker supplies both offsets and the second walker stays idle. When they differ, two walkers step together, one pair per accepted beat, and the stream ends when the shorter walk is exhausted. The configuration is captured only when a start is accepted. A final handshake or an empty request is reported by a one-cycle completion pulse.

Top module: `subvec_pair_seq`

## Requirements
- R1: While `rst` is high at a clock edge, and after that edge, `out_valid`, `busy` and `done` are all low.
- R2: A `start` pulse seen at an edge while idle, with an effective VL of at least 1, makes `busy` and `out_valid` high after that edge. The first pair has source offset 0 and destination offset 0.
- R3: Number the accepted beats from 0 as k. Beat k carries i + VL*j on both offsets, where i = k mod VL and j = k div VL, because the element index i runs fastest.
- R4: A sequence emits exactly VL * min(source length, destination length) pairs. When the two lengths are equal, this is VL times that length.
- R5: `out_last` is high on the final pair of a sequence and low on every other pair.
- R6: The pair advances only on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the offsets and `out_last` hold their values.
- R7: Each subvector length input is a 3-bit value. Values 1 to 4 are used as given, 0 is treated as 1, and 5 to 7 are treated as 4. A VL input is 7 bits wide, and values above 64 are treated as 64.
- R8: A start with an effective VL of 0 produces no valid beat and leaves `busy` low. `done` is high for the single cycle after the start edge.
- R9: A `start` pulse, or any change of the VL and length inputs, while `busy` is high has no effect on the running sequence. This also holds in the cycle of the final handshake.
- R10: After the edge that accepts the final pair, `done` is high for exactly one cycle, and `busy` and `out_valid` are low.
- R11: Asserting `rst` in the middle of a sequence returns the block to idle at the next edge, with no further valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a new sequence; accepted only when idle |
| vl | input | 7 | Element count, 0 to 64 (larger values clamp to 64) |
| src_svl | input | 3 | Source subvector length, 1 to 4 (0 and values above 4 are clamped) |
| dst_svl | input | 3 | Destination subvector length, 1 to 4 (0 and values above 4 are clamped) |
| out_ready | input | 1 | Consumer accepts the current pair |
| out_valid | output | 1 | A pair is presented |
| src_off | output | 8 | Source element offset |
| dst_off | output | 8 | Destination element offset |
| out_last | output | 1 | Current pair is the final one |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the handshake that retires the final pair, and a new start request. At that edge the block is still busy, so the request must be dropped. The bench drives `start` with fresh configuration on the last beat of several sequences. In the cycle after that edge, it checks that `done` pulses, that no valid beat appears, and that the block stays idle. Backpressure on the final beat, from a random `out_ready`, is a second overlap. There the bench checks that `out_last` holds until the handshake and that completion arrives only afterwards.

// File: rtl/svseq_pkg.sv
package svseq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;

  // Offset of element i within subvector slot j for a vector of length vl.
  function automatic int unsigned elem_offset(int unsigned i, int unsigned j,
                                              int unsigned vl);
    return i + vl * j;
  endfunction

  // Element counts above the supported maximum collapse to the maximum.
  function automatic int unsigned clamp_vl(int unsigned raw, int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

  // Subvector lengths are forced into 1..lim.
  function automatic int unsigned clamp_svl(int unsigned raw, int unsigned lim);
    if (raw == 0) return 1;
    return (raw > lim) ? lim : raw;
  endfunction

  // Number of pairs a sequence emits.
  function automatic int unsigned pair_count(int unsigned vl, int unsigned a,
                                             int unsigned b);
    return vl * ((a < b) ? a : b);
  endfunction

endpackage

// File: rtl/svseq_cfg.sv
module svseq_cfg #(
  parameter int unsigned VL_MAX  = 64,
  parameter int unsigned SVL_MAX = 4,
  parameter int unsigned VLW     = 7,
  parameter int unsigned SVW     = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           capture,
  input  logic [VLW-1:0] vl_in,
  input  logic [SVW-1:0] src_in,
  input  logic [SVW-1:0] dst_in,
  output logic [VLW-1:0] vl_q,
  output logic [SVW-1:0] src_q,
  output logic [SVW-1:0] dst_q,
  output logic           shared_q,
  output logic           vl_in_zero
);

  logic [VLW-1:0] vl_c;
  logic [SVW-1:0] src_c;
  logic [SVW-1:0] dst_c;

  assign vl_c  = VLW'(svseq_pkg::clamp_vl(32'(vl_in), VL_MAX));
  assign src_c = SVW'(svseq_pkg::clamp_svl(32'(src_in), SVL_MAX));
  assign dst_c = SVW'(svseq_pkg::clamp_svl(32'(dst_in), SVL_MAX));
  assign vl_in_zero = (vl_c == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q     <= '0;
      src_q    <= SVW'(1);
      dst_q    <= SVW'(1);
      shared_q <= 1'b1;
    end else if (capture) begin
      vl_q     <= vl_c;
      src_q    <= src_c;
      dst_q    <= dst_c;
      shared_q <= (src_c == dst_c);
    end
  end

endmodule

// File: rtl/svseq_walker.sv
module svseq_walker #(
  parameter int unsigned VLW  = 7,
  parameter int unsigned SVW  = 3,
  parameter int unsigned IW   = 6,
  parameter int unsigned JW   = 2,
  parameter int unsigned OFFW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            step,
  input  logic            en,
  input  logic [VLW-1:0]  vl,
  input  logic [SVW-1:0]  svl,
  output logic [IW-1:0]   i_idx,
  output logic [JW-1:0]   j_idx,
  output logic [OFFW-1:0] off,
  output logic            at_end
);

  logic i_wrap;
  logic j_final;

  assign i_wrap  = (VLW'(i_idx) == (vl - VLW'(1)));
  assign j_final = (SVW'(j_idx) == (svl - SVW'(1)));
  assign at_end  = i_wrap && j_final;

  // Inner loop over elements, outer loop over subvector slots.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      i_idx <= '0;
      j_idx <= '0;
    end else if (step && en && !at_end) begin
      if (i_wrap) begin
        i_idx <= '0;
        j_idx <= j_idx + JW'(1);
      end else begin
        i_idx <= i_idx + IW'(1);
      end
    end
  end

  assign off = OFFW'(svseq_pkg::elem_offset(32'(i_idx), 32'(j_idx), 32'(vl)));

  assert_index_bound_R3: assert property (@(posedge clk) disable iff (rst)
    en |-> ((32'(i_idx) < 32'(vl)) && (32'(j_idx) < 32'(svl))));

  assert_step_next_R3: assert property (@(posedge clk) disable iff (rst)
    (en && step && !at_end && !load) |=> (off == OFFW'($past(off) + OFFW'(1))));

endmodule

// File: rtl/subvec_pair_seq.sv
module subvec_pair_seq #(
  parameter int unsigned VL_MAX  = 64,
  parameter int unsigned SVL_MAX = 4,
  localparam int unsigned VLW    = $clog2(VL_MAX + 1),
  localparam int unsigned SVW    = $clog2(SVL_MAX + 1),
  localparam int unsigned OFFW   = (VL_MAX * SVL_MAX > 1) ? $clog2(VL_MAX * SVL_MAX) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [VLW-1:0]  vl,
  input  logic [SVW-1:0]  src_svl,
  input  logic [SVW-1:0]  dst_svl,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [OFFW-1:0] src_off,
  output logic [OFFW-1:0] dst_off,
  output logic            out_last,
  output logic            busy,
  output logic            done
);

  localparam int unsigned IW = (VL_MAX > 1) ? $clog2(VL_MAX) : 1;
  localparam int unsigned JW = (SVL_MAX > 1) ? $clog2(SVL_MAX) : 1;

  svseq_pkg::seq_state_e state_q;

  logic           accept_start;
  logic           launch;
  logic           empty_req;
  logic           hs;
  logic           final_hs;
  logic           running;
  logic [VLW-1:0] vl_q;
  logic [SVW-1:0] src_q;
  logic [SVW-1:0] dst_q;
  logic           shared_q;
  logic           vl_in_zero;

  logic [IW-1:0]   src_i, dst_i;
  logic [JW-1:0]   src_j, dst_j;
  logic [OFFW-1:0] w_src_off, w_dst_off;
  logic            src_end, dst_end;

  assign running      = (state_q == svseq_pkg::ST_RUN);
  assign accept_start = (state_q == svseq_pkg::ST_IDLE) && start;
  assign launch       = accept_start && !vl_in_zero;
  assign empty_req    = accept_start && vl_in_zero;
  assign hs           = out_valid && out_ready;
  assign final_hs     = hs && out_last;

  svseq_cfg #(
    .VL_MAX (VL_MAX),
    .SVL_MAX(SVL_MAX),
    .VLW    (VLW),
    .SVW    (SVW)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .capture   (accept_start),
    .vl_in     (vl),
    .src_in    (src_svl),
    .dst_in    (dst_svl),
    .vl_q      (vl_q),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .shared_q  (shared_q),
    .vl_in_zero(vl_in_zero)
  );

  // Source walker always runs; it also serves the destination when lengths match.
  svseq_walker #(
    .VLW(VLW), .SVW(SVW), .IW(IW), .JW(JW), .OFFW(OFFW)
  ) u_src_walk (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .step  (hs),
    .en    (running),
    .vl    (vl_q),
    .svl   (src_q),
    .i_idx (src_i),
    .j_idx (src_j),
    .off   (w_src_off),
    .at_end(src_end)
  );

  // Destination walker only moves when lengths differ.
  svseq_walker #(
    .VLW(VLW), .SVW(SVW), .IW(IW), .JW(JW), .OFFW(OFFW)
  ) u_dst_walk (
    .clk   (clk),
    .rst   (rst),
    .load  (launch),
    .step  (hs && !shared_q),
    .en    (running && !shared_q),
    .vl    (vl_q),
    .svl   (dst_q),
    .i_idx (dst_i),
    .j_idx (dst_j),
    .off   (w_dst_off),
    .at_end(dst_end)
  );

  assign out_valid = running;
  assign busy      = running;
  assign src_off   = w_src_off;
  assign dst_off   = shared_q ? w_src_off : w_dst_off;
  assign out_last  = running && (shared_q ? src_end : (src_end || dst_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= svseq_pkg::ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= empty_req || final_hs;
      case (state_q)
        svseq_pkg::ST_IDLE: if (launch)   state_q <= svseq_pkg::ST_RUN;
        svseq_pkg::ST_RUN:  if (final_hs) state_q <= svseq_pkg::ST_IDLE;
        default:                          state_q <= svseq_pkg::ST_IDLE;
      endcase
    end
  end

  assert_first_pair_R2: assert property (@(posedge clk) disable iff (rst)
    launch |=> (out_valid && (src_off == '0) && (dst_off == '0)));

  assert_pair_match_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !shared_q) |-> (w_src_off == w_dst_off) && (src_i == dst_i) && (src_j == dst_j));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(src_off) && $stable(dst_off) && $stable(out_last)));

  assert_empty_req_R8: assert property (@(posedge clk) disable iff (rst)
    empty_req |=> (done && !busy && !out_valid));

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(vl_q) && $stable(src_q) && $stable(dst_q)));

  assert_done_after_last_R10: assert property (@(posedge clk) disable iff (rst)
    final_hs |=> (done && !out_valid && !busy));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/sim_subvec_pair_seq.sv
module sim_subvec_pair_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int VLW  = 7;
  localparam int SVW  = 3;
  localparam int OFFW = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            start;
  logic [VLW-1:0]  vl;
  logic [SVW-1:0]  src_svl;
  logic [SVW-1:0]  dst_svl;
  logic            out_ready;
  logic            out_valid;
  logic [OFFW-1:0] src_off;
  logic [OFFW-1:0] dst_off;
  logic            out_last;
  logic            busy;
  logic            done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  subvec_pair_seq u0 (
    .clk(clk), .rst(rst), .start(start), .vl(vl), .src_svl(src_svl),
    .dst_svl(dst_svl), .out_ready(out_ready), .out_valid(out_valid),
    .src_off(src_off), .dst_off(dst_off), .out_last(out_last),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL R10 watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_vl(int v);
    if (v > 64) return 64;
    return v;
  endfunction

  function automatic int eff_svl(int s);
    if (s < 1) return 1;
    if (s > 4) return 4;
    return s;
  endfunction

  // Walk the nested loop literally to find the k-th offset.
  function automatic int exp_off(int k, int v, int len);
    int n = 0;
    for (int j = 0; j < len; j++)
      for (int i = 0; i < v; i++) begin
        if (n == k) return i + v * j;
        n++;
      end
    return -1;
  endfunction

  task automatic run_seq(int v, int s, int d, int ready_pct, bit poke_busy, bit start_on_last);
    int ev = eff_vl(v);
    int len = (eff_svl(s) < eff_svl(d)) ? eff_svl(s) : eff_svl(d);
    int total = ev * len;
    int k = 0;
    bit prev_stall = 0;
    bit rdy;
    bit last_hs;
    int prev_src = 0, prev_dst = 0, prev_last = 0;
    @(negedge clk);
    vl = VLW'(v); src_svl = SVW'(s); dst_svl = SVW'(d);
    start = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (total == 0) begin
      check_eq("R8", "valid on empty", int'(out_valid), 0);
      check_eq("R8", "busy on empty", int'(busy), 0);
      check_eq("R8", "done on empty", int'(done), 1);
      @(negedge clk);
      check_eq("R8", "done pulse width", int'(done), 0);
      return;
    end
    check_eq("R2", "valid after start", int'(out_valid), 1);
    check_eq("R2", "busy after start", int'(busy), 1);
    check_eq("R2", "first src", int'(src_off), 0);
    check_eq("R2", "first dst", int'(dst_off), 0);
    forever begin
      if (prev_stall) begin
        check_eq("R6", "src held", int'(src_off), prev_src);
        check_eq("R6", "dst held", int'(dst_off), prev_dst);
        check_eq("R6", "last held", int'(out_last), prev_last);
      end
      check_eq("R4", "valid during run", int'(out_valid), 1);
      check_eq("R3", "src offset", int'(src_off), exp_off(k, ev, len));
      check_eq("R3", "dst offset", int'(dst_off), exp_off(k, ev, len));
      check_eq("R5", "last flag", int'(out_last), int'(k == total - 1));
      rdy = ($urandom_range(99) < ready_pct);
      out_ready = rdy;
      start = 1'b0;
      if (poke_busy && $urandom_range(3) == 0) begin
        start = 1'b1;
        vl = VLW'($urandom_range(1, 64));
        src_svl = SVW'($urandom_range(1, 4));
        dst_svl = SVW'($urandom_range(1, 4));
      end
      if (start_on_last && out_last) begin
        start = 1'b1;
        vl = 7'd9;
      end
      prev_stall = out_valid && !rdy;
      prev_src = int'(src_off);
      prev_dst = int'(dst_off);
      prev_last = int'(out_last);
      last_hs = out_valid && rdy && out_last;
      if (out_valid && rdy) k++;
      @(negedge clk);
      if (last_hs || k > total) break;
    end
    start = 1'b0;
    out_ready = 1'b0;
    check_eq("R4", "pair count", k, total);
    check_eq("R10", "done after last", int'(done), 1);
    check_eq("R10", "busy after last", int'(busy), 0);
    check_eq("R10", "valid after last", int'(out_valid), 0);
    @(negedge clk);
    check_eq("R10", "done pulse width", int'(done), 0);
    check_eq("R9", "no restart from busy start", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; start = 1'b0; out_ready = 1'b0;
    vl = '0; src_svl = 3'd1; dst_svl = 3'd1;
    repeat (3) @(negedge clk);
    check_eq("R1", "valid in reset", int'(out_valid), 0);
    check_eq("R1", "busy in reset", int'(busy), 0);
    check_eq("R1", "done in reset", int'(done), 0);
    rst = 1'b0;

    run_seq(1, 1, 1, 100, 0, 0);
    run_seq(5, 2, 3, 60, 0, 1);
    run_seq(3, 4, 2, 50, 1, 1);
    run_seq(64, 4, 4, 80, 0, 0);
    run_seq(0, 2, 2, 100, 0, 0);
    run_seq(70, 0, 7, 90, 0, 0);   // R7 clamping
    run_seq(6, 7, 0, 40, 1, 0);    // R7 clamping, differing lengths
    run_seq(2, 3, 3, 20, 1, 1);

    // R11: reset in the middle of a sequence
    @(negedge clk);
    vl = 7'd10; src_svl = 3'd2; dst_svl = 3'd3; start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; out_ready = 1'b0;
    check_eq("R11", "valid after mid reset", int'(out_valid), 0);
    check_eq("R11", "busy after mid reset", int'(busy), 0);
    @(negedge clk);
    check_eq("R11", "stays idle", int'(out_valid), 0);

    for (int n = 0; n < 30; n++) begin
      int v = $urandom_range(0, 64);
      int s = ($urandom_range(7) == 0) ? $urandom_range(0, 7) : $urandom_range(1, 4);
      int d = ($urandom_range(7) == 0) ? $urandom_range(0, 7) : $urandom_range(1, 4);
      run_seq(v, s, d, $urandom_range(30, 100), bit'($urandom_range(1)), bit'($urandom_range(1)));
    end

    summary();
    $finish;
  end

endmodule